// File: doc/BRIEF.md
# Background Configuration CRC Scrubber

The scrubber looks for single-event upsets in a configuration memory while the rest of the chip keeps using that memory. Each pass reads every covered address once through a dedicated read port and shifts each word, one bit per cycle, into a 32-bit CRC. When the last word has been shifted in, the result is compared with a reference signature that was written in through a load port when the memory was programmed. A mismatch means that one or more stored bits have flipped.

A pass starts on a start request while the block is enabled and idle. A busy output is high for the whole pass. A one-cycle done pulse marks the end of the pass, and the error flag holds the result until the next pass is accepted. Dropping the enable input aborts a pass. One contiguous address range, set by parameters and meant for user RAM contents, is skipped and never read. Correcting or reloading the memory is not part of this block.

The length of a pass is the number of covered words times (word width + 2) cycles. Size the checker clock from this figure to reach the scrub interval the system needs.

Top module: `crc_scrubber`

## Requirements
- R1: The CRC uses polynomial 0x04C11DB7 and starts from a seed of 0xFFFFFFFF at every accepted start. It takes in the covered words in ascending address order, most significant bit first, one bit per cycle, and applies no final inversion. If the result equals the reference, error is 0 after the pass.
- R2: If the CRC at the end of a pass differs from the reference, error is 1 after that pass.
- R3: When ref_we is high on a clock edge, the reference is loaded from ref_data. The scrubber never computes or changes the reference itself.
- R4: Each covered address is read exactly once per pass, in ascending order. rd_en is high for one cycle per read, and the bench's memory returns rd_data on the following cycle.
- R5: Addresses EXCL_LO through EXCL_HI (10 and 11 by default) are never read, and their contents do not affect the result.
- R6: When start is accepted, busy rises in the next cycle. It stays high for exactly N × (WORD_W + 2) cycles, where N is the number of covered addresses (14 × 10 = 140 by default).
- R7: done is high for exactly one cycle: the first cycle after busy falls at the end of a completed pass. error takes its new value in that same cycle.
- R8: error holds its value until the next accepted start, which clears it to 0.
- R9: start is ignored while enable is low or a pass is in progress. Such a start neither restarts, lengthens nor clears anything.
- R10: If enable goes low during a pass, busy falls in the next cycle, done does not pulse, and error keeps its value.
- R11: A bit flip at an address that the current pass has already read does not change that pass's result. It is reported by the next pass.
- R12: After reset, busy, done, error and rd_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Checker clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Gates the block; low aborts a pass and blocks new starts |
| start | input | 1 | Request to begin a pass |
| busy | output | 1 | High while a pass is running |
| done | output | 1 | One-cycle pulse when a pass completes |
| error | output | 1 | Sticky CRC mismatch flag of the last completed pass |
| rd_en | output | 1 | Read request to the protected memory |
| rd_addr | output | $clog2(DEPTH) | Read address |
| rd_data | input | WORD_W | Word returned one cycle after rd_en |
| ref_we | input | 1 | Load strobe for the reference CRC |
| ref_data | input | 32 | Reference CRC value |

## Verification
The hardest case to reach from the ports is an upset that lands during a pass at an address the scrubber has already read. That pass must still report clean, and only the next pass may flag it. The bench watches rd_addr until the pass has moved beyond a chosen address, then flips one bit of that word in its memory model. It then checks that error is clear after the current pass and set after the next one. The expected signatures come from a separate bit-serial CRC model in the bench, which skips the excluded range.

// File: rtl/crc_scrubber.sv
module crc_scrubber #(
  parameter int          DEPTH   = 16,
  parameter int          WORD_W  = 8,
  parameter bit          EXCL_EN = 1'b1,
  parameter int          EXCL_LO = 10,
  parameter int          EXCL_HI = 11,
  parameter logic [31:0] POLY    = 32'h04C11DB7,
  parameter logic [31:0] SEED    = 32'hFFFFFFFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     error,
  output logic                     rd_en,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  input  logic [WORD_W-1:0]        rd_data,
  input  logic                     ref_we,
  input  logic [31:0]              ref_data
);
  localparam int AW    = $clog2(DEPTH);
  localparam int BW    = $clog2(WORD_W + 1);
  localparam int FIRST = (EXCL_EN && EXCL_LO == 0) ? EXCL_HI + 1 : 0;
  localparam int LAST  = (EXCL_EN && EXCL_HI == DEPTH - 1) ? EXCL_LO - 1 : DEPTH - 1;

  typedef enum logic [1:0] {IDLE, FETCH, LOAD, SHIFT} st_t;

  st_t               state;
  logic [AW-1:0]     addr;
  logic [BW-1:0]     bitc;
  logic [WORD_W-1:0] sh;
  logic [31:0]       crc, crc_nxt, ref_q;
  logic              done_q, err_q;
  logic              last_bit, start_ok;
  logic [AW:0]       inc, nxt_addr;

  assign crc_nxt  = {crc[30:0], 1'b0} ^ ((crc[31] ^ sh[WORD_W-1]) ? POLY : 32'h0);
  assign last_bit = (state == SHIFT) && (bitc == BW'(WORD_W - 1));
  assign start_ok = enable && start && (state == IDLE);
  assign inc      = {1'b0, addr} + 1'b1;
  assign nxt_addr = (EXCL_EN && inc == (AW+1)'(EXCL_LO)) ? (AW+1)'(EXCL_HI + 1) : inc;

  assign busy    = (state != IDLE);
  assign done    = done_q;
  assign error   = err_q;
  assign rd_en   = (state == FETCH);
  assign rd_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      addr   <= '0;
      bitc   <= '0;
      sh     <= '0;
      crc    <= SEED;
      ref_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ref_we) ref_q <= ref_data;
      if (!enable) begin
        state <= IDLE;
      end else begin
        case (state)
          IDLE: if (start) begin
            crc   <= SEED;
            addr  <= AW'(FIRST);
            err_q <= 1'b0;
            state <= FETCH;
          end
          FETCH: state <= LOAD;
          LOAD: begin
            sh    <= rd_data;
            bitc  <= '0;
            state <= SHIFT;
          end
          SHIFT: begin
            crc  <= crc_nxt;
            sh   <= sh << 1;
            bitc <= bitc + 1'b1;
            if (last_bit) begin
              bitc <= '0;
              if (addr == AW'(LAST)) begin
                state  <= IDLE;
                done_q <= 1'b1;
                err_q  <= (crc_nxt != ref_q);
              end else begin
                addr  <= nxt_addr[AW-1:0];
                state <= FETCH;
              end
            end
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  // R5
  no_excl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !(EXCL_EN && int'(rd_addr) >= EXCL_LO && int'(rd_addr) <= EXCL_HI));

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> int'(rd_addr) < DEPTH);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !busy && !done);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start_ok)) |-> $stable(error));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);
endmodule

// File: tb/crc_scrubber_test.sv
module crc_scrubber_test;
  localparam int DEPTH = 16;
  localparam int W     = 8;
  localparam int XLO   = 10;
  localparam int XHI   = 11;
  localparam int NINC  = DEPTH - (XHI - XLO + 1);
  localparam int PASS  = NINC * (W + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, start = 1'b0, ref_we = 1'b0;
  logic [31:0] ref_data = '0;
  logic busy, done, error, rd_en;
  logic [3:0] rd_addr;
  logic [W-1:0] rd_data;
  logic [W-1:0] mem [DEPTH];

  int checks = 0, fails = 0;
  bit finished = 0;
  int seq_cnt = 0;
  int seq [64];

  always #2.5 clk = ~clk;

  crc_scrubber uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .busy(busy), .done(done), .error(error),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ref_we(ref_we), .ref_data(ref_data)
  );

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  always @(negedge clk) if (rd_en) begin
    if (seq_cnt < 64) seq[seq_cnt] = int'(rd_addr);
    seq_cnt = seq_cnt + 1;
  end

  function automatic logic [31:0] model_crc();
    logic [31:0] c = 32'hFFFFFFFF;
    for (int a = 0; a < DEPTH; a++) begin
      if (a >= XLO && a <= XHI) continue;
      for (int b = W - 1; b >= 0; b--)
        c = {c[30:0], 1'b0} ^ ((c[31] ^ mem[a][b]) ? 32'h04C11DB7 : 32'h0);
    end
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_ref(logic [31:0] v);
    @(negedge clk); ref_we = 1'b1; ref_data = v;
    @(negedge clk); ref_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Counts busy cycles of an already running pass; returns at the first negedge with busy low.
  task automatic finish_pass(inout int cyc);
    while (busy && cyc < 100000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic full_pass(string req, logic exp_err);
    int cyc = 0;
    seq_cnt = 0;
    pulse_start();
    finish_pass(cyc);
    chk({req, " pass length (R6)"}, cyc, PASS);
    chk({req, " done pulse (R7)"}, done, 1);
    chk({req, " error result"}, error, exp_err);
    @(negedge clk);
    chk({req, " done one cycle (R7)"}, done, 0);
    chk({req, " error sticky (R8)"}, error, exp_err);
  endtask

  task automatic t_reset();
    chk("R12 busy", busy, 0);
    chk("R12 done", done, 0);
    chk("R12 error", error, 0);
    chk("R12 rd_en", rd_en, 0);
  endtask

  task automatic t_clean();
    bit ok = 1;
    int k = 0;
    load_ref(model_crc());
    full_pass("R1 clean", 0);
    chk("R4 read count", seq_cnt, NINC);
    for (int a = 0; a < DEPTH; a++) begin
      if (a >= XLO && a <= XHI) continue;
      if (seq[k] != a) ok = 0;
      k++;
    end
    chk("R4 R5 read order skips excluded", ok, 1);
  endtask

  task automatic t_flip_covered();
    mem[3][5] = ~mem[3][5];
    full_pass("R2 flipped covered bit", 1);
    mem[3][5] = ~mem[3][5];
    full_pass("R8 start clears after repair", 0);
  endtask

  task automatic t_flip_excluded();
    mem[XLO][0] = ~mem[XLO][0];
    mem[XHI][7] = ~mem[XHI][7];
    full_pass("R5 flipped excluded bits", 0);
  endtask

  task automatic t_ref_mismatch();
    logic [31:0] good = model_crc();
    load_ref(good ^ 32'h0000_0100);
    full_pass("R3 wrong reference", 1);
    load_ref(good);
    full_pass("R3 correct reference", 0);
  endtask

  task automatic t_late_flip();
    int cyc = 0;
    pulse_start();
    while (!(rd_en && rd_addr == 4'd6) && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    mem[2][3] = ~mem[2][3];
    cyc = 0;
    finish_pass(cyc);
    chk("R11 flip behind scan not seen", error, 0);
    full_pass("R11 flip seen next pass", 1);
    mem[2][3] = ~mem[2][3];
    full_pass("R11 restored", 0);
  endtask

  task automatic t_start_busy();
    int cyc = 0;
    pulse_start();
    repeat (50) begin cyc++; @(negedge clk); end
    start = 1'b1; @(negedge clk); start = 1'b0; cyc++;
    finish_pass(cyc);
    chk("R9 restart ignored while busy", cyc, PASS);
    chk("R9 done after ignored start", done, 1);
  endtask

  task automatic t_enable_low();
    mem[1][0] = ~mem[1][0];
    full_pass("R9 prepare error", 1);
    mem[1][0] = ~mem[1][0];
    enable = 1'b0;
    pulse_start();
    repeat (3) @(negedge clk);
    chk("R9 start ignored when disabled busy", busy, 0);
    chk("R9 start ignored when disabled error", error, 1);
    enable = 1'b1;
  endtask

  task automatic t_abort();
    bit saw_done = 0;
    pulse_start();
    repeat (30) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 busy falls", busy, 0);
    repeat (200) begin
      if (done) saw_done = 1;
      @(negedge clk);
    end
    chk("R10 no done", saw_done, 0);
    chk("R10 error unchanged", error, 0);
    enable = 1'b1;
    full_pass("R10 clean pass after abort", 0);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = W'(a * 37 + 11);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    t_clean();
    t_flip_covered();
    t_flip_excluded();
    t_ref_mismatch();
    t_late_flip();
    t_start_busy();
    t_enable_low();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule